// File: doc/BRIEF.md
# Watermark-Driven Clock-Gated Register Bank

This block is a bank of flip-flops split into equal words, with an integrated clock gate in front of each word. Its purpose is to put a known pattern onto the supply current. Clock-tree switching, not data switching, carries that pattern. An external sequence generator supplies one watermark bit per cycle. While watermark mode is active, that bit alone opens or closes every word's clock gate. When the bank is one clocked sub-block of larger logic, watermark mode is turned off and the gates follow the host's functional clock enable instead.

All words are cleared to zero and normally stay there, so an open gate costs only clock power. A count input selects how many of the lowest-numbered words also invert their contents on every clock they receive. This adds data-switching power on top of clock power. Each gate is a latch that is transparent while the clock is low, followed by an AND with the clock. An enable that changes while the clock is high therefore cannot shorten or create a pulse.

Top module: `wm_gated_bank`

## Requirements
- R1: A synchronous, active-high `rst` clears every word to zero at the next rising clock edge. This holds whatever the mode, watermark bit and functional enable are.
- R2: With `wm_mode`=1 and `wm_bit`=1, every word receives a clock edge in that cycle, whatever `func_en` is.
- R3: With `wm_mode`=1 and `wm_bit`=0, no word receives a clock edge and every word holds its value, whatever `func_en` is.
- R4: With `wm_mode`=0, the gate enable equals `func_en`, and `wm_bit` has no effect on any word.
- R5: Word w occupies `bank_q[w*WORD_W +: WORD_W]`. A word whose index is below `tog_words` inverts all of its bits on each clock edge it receives.
- R6: A word whose index is `tog_words` or above loads zero on each clock edge it receives. With `tog_words`=0, the bank therefore stays all zero after reset.
- R7: A `tog_words` value equal to or above the word count makes every word toggle.
- R8: The enable is captured while the clock is low. A change to the enable during the high phase does not affect the edge that began that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset, forces all gates open |
| wm_bit | input | 1 | Current watermark sequence bit |
| func_en | input | 1 | Functional clock enable from host logic |
| wm_mode | input | 1 | 1: gates follow `wm_bit`; 0: gates follow `func_en` |
| tog_words | input | TOG_W (6) | Number of low-index words that toggle data |
| bank_q | output | NUM_WORDS*WORD_W (1024) | Concatenated contents of all words |

## Verification
A gate that passes a clock it should block shows up one cycle later. A toggling word would flip when it should hold, or a stale word would fall to zero. A gate that blocks a needed edge leaves a word unflipped at the same point. A broken enable mux or a faulty count comparator gives the wrong word pattern right after the first edge in which it matters. The bench therefore compares every word after every cycle, across all mode, bit, enable and count combinations. Glitch sensitivity is only visible when the enable moves mid-high-phase, so a dedicated test changes it there and checks the following sample.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Gate enable source selection
  typedef enum logic {
    EN_FUNCTIONAL = 1'b0,
    EN_WATERMARK  = 1'b1
  } en_src_e;

  // Word index is inside the toggling group when below the count
  function automatic logic word_toggles(input int unsigned idx, input int unsigned count);
    return idx < count;
  endfunction

endpackage

// File: rtl/wm_enable_ctrl.sv
module wm_enable_ctrl
  import wm_pkg::*;
(
  input  logic rst,
  input  logic wm_mode,
  input  logic wm_bit,
  input  logic func_en,
  output logic gate_en
);

  en_src_e src;

  always_comb begin
    src = en_src_e'(wm_mode);
    // Reset needs an edge at every word, so all gates open
    if (rst) begin
      gate_en = 1'b1;
    end else if (src == EN_WATERMARK) begin
      gate_en = wm_bit;
    end else begin
      gate_en = func_en;
    end
  end

endmodule

// File: rtl/wm_clk_gate.sv
module wm_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);

  logic en_lat;

  // Transparent while clk is low; closed through the high phase
  always_latch begin
    if (!clk) begin
      en_lat = en;
    end
  end

  assign gclk = clk & en_lat;

endmodule

// File: rtl/wm_word_reg.sv
module wm_word_reg #(
  parameter int WORD_W = 32
) (
  input  logic              gclk,
  input  logic              rst,
  input  logic              tog_sel,
  output logic [WORD_W-1:0] q
);

  always_ff @(posedge gclk) begin
    if (rst) begin
      q <= '0;
    end else if (tog_sel) begin
      q <= ~q;
    end else begin
      q <= '0;
    end
  end

endmodule

// File: rtl/wm_gated_bank.sv
module wm_gated_bank #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_W    = 32,
  parameter int TOG_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wm_bit,
  input  logic                          func_en,
  input  logic                          wm_mode,
  input  logic [TOG_W-1:0]              tog_words,
  output logic [NUM_WORDS*WORD_W-1:0]   bank_q
);

  localparam int BANK_W = NUM_WORDS * WORD_W;

  logic gate_en;

  wm_enable_ctrl u_en (
    .rst     (rst),
    .wm_mode (wm_mode),
    .wm_bit  (wm_bit),
    .func_en (func_en),
    .gate_en (gate_en)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic              gclk_w;
    logic              sel_w;
    logic [WORD_W-1:0] q_w;

    assign sel_w = wm_pkg::word_toggles(w, int'(tog_words));

    wm_clk_gate u_icg (
      .clk  (clk),
      .en   (gate_en),
      .gclk (gclk_w)
    );

    wm_word_reg #(.WORD_W(WORD_W)) u_reg (
      .gclk    (gclk_w),
      .rst     (rst),
      .tog_sel (sel_w),
      .q       (q_w)
    );

    assign bank_q[w*WORD_W +: WORD_W] = q_w;
  end

  if (BANK_W < 1) begin : g_bad_cfg
    initial $error("bank must hold at least one bit");
  end

endmodule

// File: rtl/wm_bank_chk.sv
module wm_bank_chk #(
  parameter int NUM_WORDS = 32,
  parameter int WORD_W    = 32,
  parameter int TOG_W     = $clog2(NUM_WORDS + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wm_bit,
  input logic                        func_en,
  input logic                        wm_mode,
  input logic [TOG_W-1:0]            tog_words,
  input logic [NUM_WORDS*WORD_W-1:0] bank_q
);

  logic eff_en;
  assign eff_en = wm_mode ? wm_bit : func_en;

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (bank_q == '0)); // R1

  AST_WM_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wm_mode && !wm_bit) |=> $stable(bank_q)); // R3

  AST_FUNC_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wm_mode && !func_en) |=> $stable(bank_q)); // R4

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_chk
    localparam logic [TOG_W-1:0] IDX = TOG_W'(w);
    logic [WORD_W-1:0] q_w;
    assign q_w = bank_q[w*WORD_W +: WORD_W];

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
      (eff_en && (IDX < tog_words)) |=> (q_w == ~$past(q_w))); // R5

    AST_IDLE_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (eff_en && (IDX >= tog_words)) |=> (q_w == '0)); // R6

    AST_WORD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
      (q_w == '0) || (q_w == '1)); // R5
  end

endmodule

bind wm_gated_bank wm_bank_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (WORD_W),
  .TOG_W     (TOG_W)
) u_chk (.*);

// File: tb/test_wm_gated_bank.sv
module test_wm_gated_bank;

  localparam int NW    = 32;
  localparam int WW    = 32;
  localparam int TW    = $clog2(NW + 1);
  localparam int HALF  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wm_bit = 1'b0;
  logic          func_en = 1'b0;
  logic          wm_mode = 1'b0;
  logic [TW-1:0] tog_words = '0;
  logic [NW*WW-1:0] bank_q;

  int  n_chk = 0;
  int  n_bad = 0;
  logic exp_ones [NW];

  always #HALF clk = ~clk;

  wm_gated_bank #(.NUM_WORDS(NW), .WORD_W(WW)) i_wm_gated_bank (
    .clk       (clk),
    .rst       (rst),
    .wm_bit    (wm_bit),
    .func_en   (func_en),
    .wm_mode   (wm_mode),
    .tog_words (tog_words),
    .bank_q    (bank_q)
  );

  // Model update for one edge with given enable
  task automatic model_edge(input logic r, input logic en, input int tw);
    for (int w = 0; w < NW; w++) begin
      if (r) exp_ones[w] = 1'b0;
      else if (en) exp_ones[w] = (w < tw) ? ~exp_ones[w] : 1'b0;
    end
  endtask

  task automatic compare(input string tag);
    logic [WW-1:0] expv;
    logic [WW-1:0] act;
    int bad_w;
    bad_w = -1;
    n_chk++;
    for (int w = 0; w < NW; w++) begin
      expv = exp_ones[w] ? '1 : '0;
      act  = bank_q[w*WW +: WW];
      if (act !== expv && bad_w < 0) begin
        bad_w = w;
        $display("FAIL %s word %0d: actual %h expected %h", tag, w, act, expv);
      end
    end
    if (bad_w >= 0) n_bad++;
  endtask

  // Drive at negedge, one edge, sample at next negedge
  task automatic step(input logic r, input logic m, input logic wb,
                      input logic fe, input int tw, input string tag);
    rst = r; wm_mode = m; wm_bit = wb; func_en = fe; tog_words = TW'(tw);
    @(posedge clk);
    model_edge(r, r | (m ? wb : fe), tw);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) exp_ones[w] = 1'b0;
    // R1: reset state
    step(1, 1, 0, 0, NW, "R1 reset state");
    step(0, 0, 0, 0, 0, "R6 idle after reset");

    // Sweep all mode/bit/enable combinations over every toggle count
    for (int tw = 0; tw <= NW + 1; tw++) begin
      for (int c = 0; c < 8; c++) begin
        logic m, wb, fe;
        string tag;
        m = c[2]; wb = c[1]; fe = c[0];
        if (m) tag = wb ? "R2 watermark open" : "R3 watermark closed";
        else   tag = "R4 functional enable";
        if (tw == 0)       tag = {tag, " / R6 baseline"};
        else if (tw >= NW) tag = {tag, " / R7 all words"};
        else               tag = {tag, " / R5 partial toggle"};
        step(0, m, wb, fe, tw, tag);
        step(0, m, wb, fe, tw, tag);
      end
    end

    // R1: reset while the watermark would keep gates closed
    step(0, 1, 1, 0, NW, "R7 fill");
    step(1, 1, 0, 0, NW, "R1 reset with closed gate");

    // R6: shrink the toggle group while gated, then open
    step(0, 1, 1, 0, 8, "R5 fill low words");
    step(0, 1, 0, 0, 3, "R3 hold stale words");
    step(0, 1, 1, 0, 3, "R6 stale words cleared");

    // R8: enable falls during the high phase; the edge must still occur
    rst = 0; wm_mode = 0; func_en = 1; tog_words = TW'(NW);
    @(posedge clk); #3 func_en = 0;
    model_edge(0, 1, NW);
    @(negedge clk); compare("R8 late fall keeps edge");
    // R8: enable rises during the high phase; no edge may occur
    @(posedge clk); #3 func_en = 1;
    @(negedge clk); compare("R8 late rise adds no edge");
    func_en = 0;
    @(posedge clk); @(negedge clk); compare("R8 gate closed next cycle");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule